// File: doc/BRIEF.md
# Rename Snapshot Tracker and Selector

This block keeps a small circular record of reorder-buffer indices, one for each instruction at which the renamer took a checkpoint of its mapping state. The renamer offers a checkpoint through its first output slot. The block accepts it only when there is room and no redirect is in flight. When commit retires the instruction that the oldest record names, that record leaves the buffer.

When a redirect arrives, the block reports combinationally whether some held checkpoint is old enough to restore from, and which slot holds it. It searches from the youngest record towards the oldest. In the same cycle it discards every record that is younger than the redirecting instruction and moves its write pointer back to just past the newest record that survives. The rename table and the reorder buffer use the selection to restore their state. This block holds only the indices, not the rename table contents.

An index is `ROB_W+1` bits wide. Bit `ROB_W` is a wrap flag and the lower bits are the position in the reorder buffer.

Top module: `snap_tracker`

## Requirements
- R1: When `ren_fire` and `ren_snap` are high, the buffer is not full and `redir_valid` is low, `snap_taken` is high in that cycle and `ren_idx` is recorded as the youngest entry.
- R2: `full` is high while the buffer holds `SNAPS` entries; while it is high, `snap_taken` stays low and nothing is recorded.
- R3: In a cycle with `redir_valid` high, `snap_taken` is low and no entry is recorded.
- R4: `snap_deq` is high, and the oldest entry is removed, only when that entry is valid, `cmt_mode` is high, and some lane with its `cmt_valid` bit set carries an index equal to the stored one; lane l uses bits `[l*(ROB_W+1) +: ROB_W+1]` of `cmt_idx`.
- R5: `use_snap` is high exactly when some held entry is not younger than `redir_idx`.
- R6: `snap_sel` names the first qualifying slot met when scanning from the slot just below the write pointer downwards, wrapping round; when no slot qualifies it is 0.
- R7: With `redir_valid` high, entries younger than `redir_idx` are dropped and the write pointer moves to just after the selected slot, or to the read pointer when no entry survives.
- R8: Age order: with equal wrap flags a smaller or equal position counts as not younger; with different flags, a strictly larger position counts as older.
- R9: After reset the buffer is empty: `full`, `snap_deq` and `use_snap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_fire | input | 1 | First rename slot fires |
| ren_snap | input | 1 | That slot requests a checkpoint |
| ren_idx | input | ROB_W+1 | Reorder-buffer index of that slot |
| snap_taken | output | 1 | Checkpoint accepted (gated request flag) |
| full | output | 1 | All slots occupied |
| cmt_mode | input | 1 | Reorder buffer is committing (not walking) |
| cmt_valid | input | LANES | Per-lane commit valid |
| cmt_idx | input | LANES*(ROB_W+1) | Per-lane committed index |
| snap_deq | output | 1 | Oldest entry retired this cycle |
| redir_valid | input | 1 | Redirect this cycle; flushes younger entries |
| redir_idx | input | ROB_W+1 | Index of the redirecting instruction |
| use_snap | output | 1 | A checkpoint is usable for `redir_idx` |
| snap_sel | output | $clog2(SNAPS) | Slot to restore from |

## Verification
The bench builds the block with four slots, a 4-bit position plus wrap flag, and two commit lanes. Four slots fill in a few cycles, so full suppression and dequeue while full come up early. A 16-entry index space lets the stored indices cross the wrap flag, and the write pointer's own wrap bit flips within the run, so the backward scan and the rollback are both exercised past wraparound.

// File: rtl/snap_tracker.sv
module snap_tracker #(
  parameter int SNAPS = 4,
  parameter int ROB_W = 4,
  parameter int LANES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren_fire,
  input  logic                         ren_snap,
  input  logic [ROB_W:0]               ren_idx,
  output logic                         snap_taken,
  output logic                         full,
  input  logic                         cmt_mode,
  input  logic [LANES-1:0]             cmt_valid,
  input  logic [LANES*(ROB_W+1)-1:0]   cmt_idx,
  output logic                         snap_deq,
  input  logic                         redir_valid,
  input  logic [ROB_W:0]               redir_idx,
  output logic                         use_snap,
  output logic [$clog2(SNAPS)-1:0]     snap_sel
);
  localparam int IW = ROB_W + 1;
  localparam int PW = $clog2(SNAPS);

  logic [IW-1:0]    ent [SNAPS];
  logic [SNAPS-1:0] vld;
  logic [PW:0]      enq_p, deq_p, sel_p, deq_next;
  logic             hit;

  function automatic logic not_younger(input logic [IW-1:0] a, input logic [IW-1:0] b);
    if (a[ROB_W] == b[ROB_W]) return a[ROB_W-1:0] <= b[ROB_W-1:0];
    return a[ROB_W-1:0] > b[ROB_W-1:0];
  endfunction

  assign full       = (enq_p[PW] != deq_p[PW]) && (enq_p[PW-1:0] == deq_p[PW-1:0]);
  assign snap_taken = ren_fire & ren_snap & ~full & ~redir_valid;

  always_comb begin
    hit = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (cmt_valid[l] && cmt_idx[l*IW +: IW] == ent[deq_p[PW-1:0]]) hit = 1'b1;
  end

  assign snap_deq = vld[deq_p[PW-1:0]] & cmt_mode & hit;
  assign deq_next = deq_p + {{PW{1'b0}}, snap_deq};

  always_comb begin
    use_snap = 1'b0;
    snap_sel = '0;
    sel_p    = deq_p;
    for (int i = SNAPS; i >= 1; i--) begin
      logic [PW:0] p;
      p = enq_p - (PW+1)'(i);
      if (vld[p[PW-1:0]] && not_younger(ent[p[PW-1:0]], redir_idx)) begin
        use_snap = 1'b1;
        snap_sel = p[PW-1:0];
        sel_p    = p;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      enq_p <= '0;
      deq_p <= '0;
    end else begin
      if (snap_deq) begin
        vld[deq_p[PW-1:0]] <= 1'b0;
        deq_p <= deq_next;
      end
      if (redir_valid) begin
        for (int k = 0; k < SNAPS; k++)
          if (!not_younger(ent[k], redir_idx)) vld[k] <= 1'b0;
        enq_p <= use_snap ? sel_p + 1'b1 : deq_next;
      end else if (snap_taken) begin
        ent[enq_p[PW-1:0]] <= ren_idx;
        vld[enq_p[PW-1:0]] <= 1'b1;
        enq_p <= enq_p + 1'b1;
      end
    end
  end
endmodule

module snap_tracker_chk #(
  parameter int SNAPS = 4,
  parameter int ROB_W = 4,
  parameter int LANES = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       snap_taken,
  input logic                       full,
  input logic                       cmt_mode,
  input logic [LANES-1:0]           cmt_valid,
  input logic                       snap_deq,
  input logic                       redir_valid,
  input logic                       use_snap,
  input logic [$clog2(SNAPS)-1:0]   snap_sel
);
  assert_no_take_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !snap_taken);
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full && !snap_deq && !redir_valid |=> full);
  assert_no_take_redir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !snap_taken);
  assert_deq_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_deq |-> cmt_mode && (|cmt_valid));
  assert_room_after_deq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_deq |=> !full);
  assert_default_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !use_snap |-> snap_sel == '0);
  assert_flush_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !use_snap |=> !full);
endmodule

bind snap_tracker snap_tracker_chk #(.SNAPS(SNAPS), .ROB_W(ROB_W), .LANES(LANES)) u_chk (.*);

// File: tb/snap_tracker_test.sv
module snap_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_fire = 0, ren_snap = 0, cmt_mode = 0, redir_valid = 0;
  logic [4:0] ren_idx = '0, redir_idx = '0;
  logic [1:0] cmt_valid = '0;
  logic [9:0] cmt_idx = '0;
  logic snap_taken, full, snap_deq, use_snap;
  logic [1:0] snap_sel;
  int n_run = 0, n_fail = 0;

  snap_tracker uut (.clk(clk), .rst_n(rst_n), .ren_fire(ren_fire), .ren_snap(ren_snap),
    .ren_idx(ren_idx), .snap_taken(snap_taken), .full(full), .cmt_mode(cmt_mode),
    .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .snap_deq(snap_deq),
    .redir_valid(redir_valid), .redir_idx(redir_idx), .use_snap(use_snap), .snap_sel(snap_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {enq, eidx, cm, cv, c0, c1, rv, ridx, x_taken, x_use, x_sel, x_full, x_deq}
  localparam logic [30:0] VEC [NV] = '{
    {1'b1,5'h02,1'b0,2'b00,5'h00,5'h00,1'b0,5'h00, 1'b1,1'b0,2'd0,1'b0,1'b0},
    {1'b1,5'h05,1'b0,2'b00,5'h00,5'h00,1'b0,5'h03, 1'b1,1'b1,2'd0,1'b0,1'b0},
    {1'b1,5'h09,1'b0,2'b00,5'h00,5'h00,1'b0,5'h07, 1'b1,1'b1,2'd1,1'b0,1'b0},
    {1'b1,5'h0C,1'b0,2'b00,5'h00,5'h00,1'b0,5'h01, 1'b1,1'b0,2'd0,1'b0,1'b0},
    {1'b1,5'h0E,1'b0,2'b00,5'h00,5'h00,1'b0,5'h0C, 1'b0,1'b1,2'd3,1'b1,1'b0},
    {1'b0,5'h00,1'b1,2'b01,5'h03,5'h00,1'b0,5'h0A, 1'b0,1'b1,2'd2,1'b1,1'b0},
    {1'b0,5'h00,1'b1,2'b10,5'h02,5'h02,1'b0,5'h05, 1'b0,1'b1,2'd1,1'b1,1'b1},
    {1'b1,5'h11,1'b0,2'b11,5'h05,5'h05,1'b0,5'h02, 1'b1,1'b0,2'd0,1'b0,1'b0},
    {1'b0,5'h00,1'b0,2'b00,5'h00,5'h00,1'b1,5'h10, 1'b0,1'b1,2'd3,1'b1,1'b0},
    {1'b1,5'h13,1'b0,2'b00,5'h00,5'h00,1'b0,5'h09, 1'b1,1'b1,2'd2,1'b0,1'b0},
    {1'b1,5'h14,1'b0,2'b00,5'h00,5'h00,1'b0,5'h15, 1'b0,1'b1,2'd0,1'b1,1'b0},
    {1'b1,5'h14,1'b0,2'b00,5'h00,5'h00,1'b1,5'h04, 1'b0,1'b0,2'd0,1'b1,1'b0},
    {1'b1,5'h06,1'b0,2'b00,5'h00,5'h00,1'b1,5'h00, 1'b0,1'b0,2'd0,1'b0,1'b0},
    {1'b1,5'h06,1'b0,2'b00,5'h00,5'h00,1'b0,5'h00, 1'b1,1'b0,2'd0,1'b0,1'b0},
    {1'b0,5'h00,1'b1,2'b01,5'h06,5'h00,1'b0,5'h06, 1'b0,1'b1,2'd1,1'b0,1'b1}
  };

  task automatic check(input string tag, input int v, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s vec %0d: actual %0d expected %0d", tag, v, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog R9: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; redir_idx = 5'h1F;
    #1;
    check("R9 full", -1, {1'b0, full}, 2'd0);
    check("R9 use_snap", -1, {1'b0, use_snap}, 2'd0);
    check("R9 snap_deq", -1, {1'b0, snap_deq}, 2'd0);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {ren_fire, ren_idx, cmt_mode, cmt_valid, cmt_idx[4:0], cmt_idx[9:5],
       redir_valid, redir_idx} = VEC[v][30:6];
      ren_snap = ren_fire;
      #1;
      check("R1 R2 R3 snap_taken", v, {1'b0, snap_taken}, {1'b0, VEC[v][5]});
      check("R5 R8 use_snap", v, {1'b0, use_snap}, {1'b0, VEC[v][4]});
      check("R6 R8 snap_sel", v, snap_sel, VEC[v][3:2]);
      check("R2 R7 full", v, {1'b0, full}, {1'b0, VEC[v][1]});
      check("R4 snap_deq", v, {1'b0, snap_deq}, {1'b0, VEC[v][0]});
    end
    // fire without the checkpoint flag records nothing (R1)
    @(negedge clk);
    {ren_fire, ren_snap, ren_idx, cmt_mode, cmt_valid, redir_valid} = '0;
    ren_fire = 1'b1; redir_idx = 5'h1F;
    #1;
    check("R1 snap_taken no flag", NV, {1'b0, snap_taken}, 2'd0);
    @(negedge clk); ren_fire = 1'b0;
    #1;
    check("R1 R5 empty after drain", NV+1, {1'b0, use_snap}, 2'd0);
    check("R2 full after drain", NV+1, {1'b0, full}, 2'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule